// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles the outcome of a short relative branch in a 16-bit processor pipeline. Each cycle it takes an instruction word, the program counter (which fetch has already advanced past the instruction), and the four status flags: zero, carry, negative and overflow. It then registers two results: whether the branch is taken, and the program counter to use next.

A branch instruction is marked by the value 001 in its top three bits. The next three bits pick one of eight conditions, and the low ten bits hold a signed word offset. A taken branch adds twice that offset to the advanced PC. A branch that is not taken, or a word that is not a branch at all, passes the PC through unchanged. Both outputs appear one clock after the inputs are sampled.

Top module: `jmp_unit`

## Requirements
- R1: While rst_n is low, taken_o and next_pc_o are both 0.
- R2: With instr_i[15:13]=001, condition code instr_i[12:10]=000 takes the branch when Z=0, and code 001 takes it when Z=1.
- R3: Condition code 010 takes the branch when C=0, and code 011 takes it when C=1.
- R4: Condition code 100 takes the branch when N=1, whatever the other flags are.
- R5: Condition code 101 takes the branch when N equals V (signed greater-or-equal), and code 110 takes it when N differs from V (signed less-than).
- R6: Condition code 111 always takes the branch, whatever the flags are.
- R7: A taken branch gives next_pc_o = pc_i + 2 × sign-extended instr_i[9:0], modulo 2^16. The result has the same low bit as pc_i.
- R8: A branch that is not taken gives next_pc_o = pc_i.
- R9: Offset 0x3FF (−1) gives pc_i − 2, the address of the branch itself. Offsets that cross 0x0000 or 0xFFFF wrap around.
- R10: When instr_i[15:13] is not 001, taken_o is 0 and next_pc_o = pc_i.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter already advanced past the instruction |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| next_pc_o | output | 16 | Registered next program counter |
| taken_o | output | 1 | Registered branch-taken indication |

## Verification
The bench steps through all sixteen flag combinations for each condition code. A design that swapped the signed greater-or-equal and less-than tests, or tested N alone for them, would give the wrong result as soon as V is 1. Offsets at the extremes (0x1FF, 0x200, 0x3FF) and PCs near both ends of the address space expose a missing sign extension, a missing ×2 scaling, or lost wraparound. Non-branch opcodes combined with flag values that would otherwise satisfy a condition catch a decoder that ignores the format bits. Random words that mix all of these check the one-cycle latency on every clock.

// File: rtl/jmp_pkg.sv
package jmp_pkg;

    typedef enum logic [2:0] {
        CC_NZ  = 3'b000,
        CC_ZS  = 3'b001,
        CC_NC  = 3'b010,
        CC_CS  = 3'b011,
        CC_NEG = 3'b100,
        CC_GE  = 3'b101,
        CC_LT  = 3'b110,
        CC_ANY = 3'b111
    } cond_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

    localparam logic [2:0] BRANCH_FMT = 3'b001;

endpackage

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
    import jmp_pkg::*;
(
    input  cond_e  cond_i,
    input  flags_t flags_i,
    output logic   hit_o
);

    always_comb begin
        unique case (cond_i)
            CC_NZ:   hit_o = ~flags_i.z;
            CC_ZS:   hit_o = flags_i.z;
            CC_NC:   hit_o = ~flags_i.c;
            CC_CS:   hit_o = flags_i.c;
            CC_NEG:  hit_o = flags_i.n;
            CC_GE:   hit_o = ~(flags_i.n ^ flags_i.v);
            CC_LT:   hit_o = flags_i.n ^ flags_i.v;
            CC_ANY:  hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 10
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [PC_W-1:0]  target_o
);

    localparam int EXT_W = PC_W - OFS_W - 1;

    logic [PC_W-1:0] disp;

    always_comb begin
        disp     = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, 1'b0};
        target_o = pc_i + disp;
    end

endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
    import jmp_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int PC_W    = 16,
    parameter int OFS_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    input  logic               flag_n_i,
    input  logic               flag_v_i,
    output logic [PC_W-1:0]    next_pc_o,
    output logic               taken_o
);

    localparam int FMT_HI  = INSTR_W - 1;
    localparam int COND_HI = INSTR_W - 4;

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] pc;
    } res_t;

    res_t   res_d, res_q;
    flags_t flags;
    logic   is_branch;
    logic   cond_hit;
    logic [PC_W-1:0] target;

    assign flags = '{z: flag_z_i, c: flag_c_i, n: flag_n_i, v: flag_v_i};

    jmp_cond_eval u_cond (
        .cond_i  (cond_e'(instr_i[COND_HI -: 3])),
        .flags_i (flags),
        .hit_o   (cond_hit)
    );

    jmp_target_calc #(
        .PC_W  (PC_W),
        .OFS_W (OFS_W)
    ) u_tgt (
        .pc_i     (pc_i),
        .ofs_i    (instr_i[OFS_W-1:0]),
        .target_o (target)
    );

    always_comb begin
        is_branch   = (instr_i[FMT_HI -: 3] == BRANCH_FMT);
        res_d.taken = is_branch & cond_hit;
        res_d.pc    = res_d.taken ? target : pc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign next_pc_o = res_q.pc;
    assign taken_o   = res_q.taken;

endmodule

// File: rtl/jmp_unit_chk.sv
module jmp_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  fmt_cond,
    input logic [15:0] pc_i,
    input logic        z,
    input logic        n,
    input logic        v,
    input logic [15:0] next_pc_o,
    input logic        taken_o
);

    logic hist_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!taken_o && next_pc_o == 16'h0)); // R1

    AST_ZERO_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(fmt_cond) == 6'b001000) |-> (taken_o == !$past(z))); // R2

    AST_GE_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(fmt_cond) == 6'b001101) |-> (taken_o == ($past(n) == $past(v)))); // R5

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(fmt_cond) == 6'b001111) |-> taken_o); // R6

    AST_TARGET_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && taken_o) |-> (next_pc_o[0] == $past(pc_i[0]))); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !taken_o) |-> (next_pc_o == $past(pc_i))); // R8

    AST_NON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(fmt_cond[5:3]) != 3'b001) |-> !taken_o); // R10

endmodule

bind jmp_unit jmp_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_cond  (instr_i[15:10]),
    .pc_i      (pc_i),
    .z         (flag_z_i),
    .n         (flag_n_i),
    .v         (flag_v_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o)
);

// File: tb/sim_jmp_unit.sv
module sim_jmp_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] instr;
    logic [15:0] pc;
    logic        fz, fc, fn, fv;
    logic [15:0] next_pc;
    logic        taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jmp_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .pc_i      (pc),
        .flag_z_i  (fz),
        .flag_c_i  (fc),
        .flag_n_i  (fn),
        .flag_v_i  (fv),
        .next_pc_o (next_pc),
        .taken_o   (taken)
    );

    function automatic bit model_taken(input logic [15:0] w, input bit z, input bit c,
                                       input bit n, input bit v);
        if (w[15:13] != 3'b001) return 1'b0;
        case (int'(w[12:10]))
            0: return !z;
            1: return z;
            2: return !c;
            3: return c;
            4: return n;
            5: return n == v;
            6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] model_pc(input logic [15:0] w, input logic [15:0] p, input bit tk);
        int off;
        if (!tk) return p;
        off = int'(w[9:0]);
        if (off >= 512) off = off - 1024;
        return 16'((int'(p) + 2 * off) & 32'hFFFF);
    endfunction

    task automatic check(input string req, input bit exp_tk, input logic [15:0] exp_pc);
        n_checks++;
        if (taken !== exp_tk || next_pc !== exp_pc) begin
            n_fail++;
            $display("FAIL %s: taken=%0b next_pc=%04h expected taken=%0b next_pc=%04h",
                     req, taken, next_pc, exp_tk, exp_pc);
        end
    endtask

    // drive after a negedge, register at posedge, compare at the next negedge
    task automatic step(input string req, input logic [15:0] w, input logic [15:0] p,
                        input bit z, input bit c, input bit n, input bit v);
        bit tk;
        instr = w; pc = p; fz = z; fc = c; fn = n; fv = v;
        tk = model_taken(w, z, c, n, v);
        @(posedge clk);
        @(negedge clk);
        check(req, tk, model_pc(w, p, tk));
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        instr = 16'h3C05; pc = 16'h1234; fz = 1; fc = 1; fn = 1; fv = 1;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 16'h0000);
        rst_n = 1'b1;

        // every condition against every flag pattern; R2 R3 R4 R5 R6
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 16; f++) begin
                string r;
                r = (cc < 2) ? "R2" : (cc < 4) ? "R3" : (cc == 4) ? "R4" : (cc < 7) ? "R5" : "R6";
                step(r, {3'b001, 3'(cc), 10'h010}, 16'h4000, f[3], f[2], f[1], f[0]);
            end
        end

        // R7 offset extremes and scaling
        step("R7", 16'h3DFF, 16'h8000, 0, 0, 0, 0);
        check("R7", 1'b1, 16'h83FE);
        step("R7", 16'h3E00, 16'h8000, 0, 0, 0, 0);
        check("R7", 1'b1, 16'h7C00);
        step("R7", 16'h3C01, 16'h0101, 0, 0, 0, 0);
        check("R7", 1'b1, 16'h0103);
        // R9 self-loop and wraparound
        step("R9", 16'h3FFF, 16'hC01C, 0, 0, 0, 0);
        check("R9", 1'b1, 16'hC01A);
        step("R9", 16'h3C10, 16'hFFF0, 0, 0, 0, 0);
        check("R9", 1'b1, 16'h0010);
        step("R9", 16'h3FF0, 16'h0004, 0, 0, 0, 0);
        check("R9", 1'b1, 16'hFFE4);
        // R8 not taken passes PC
        step("R8", 16'h2005, 16'hABCE, 1, 0, 0, 0);
        check("R8", 1'b0, 16'hABCE);
        // R10 non-branch formats with satisfying flags
        for (int fmt = 0; fmt < 8; fmt++) begin
            if (fmt != 1) begin
                step("R10", {3'(fmt), 3'b111, 10'h155}, 16'h5550, 1, 1, 1, 1);
                check("R10", 1'b0, 16'h5550);
            end
        end

        // R11 back-to-back random words, one-cycle latency on every clock
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (i % 2 == 0) w[15:13] = 3'b001;
            step("R11", w, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R1 reset mid-run clears outputs
        instr = 16'h3C40; pc = 16'h2222;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", 1'b0, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule